// File: doc/BRIEF.md
# Pipeline Exception Arbiter and Redirect Unit

This block sits beside a four-stage instruction pipeline (fetch, decode, execute, memory) and decides, every cycle, whether control must leave the running program. Fetch can report an instruction page fault and decode can report an undefined opcode. Execute can report an arithmetic overflow, memory can report a data page fault, and an external interrupt line can request service. Each stage presents the address of the instruction it holds and a valid bit. Requests from empty stages count for nothing.

When one or more requests are live, the unit picks the request of the oldest instruction. That instruction sits in the deepest stage. The unit asserts a take strobe in the same cycle, with write enables for the cause and fault-address registers and a redirect to the fixed handler address. It also flushes the chosen stage and every shallower stage. Deeper stages hold older instructions, so they keep running to completion. An interrupt is attached to the instruction waiting in decode, which makes it a boundary event. It loses to any older synchronous fault. A store issued by a faulting memory-stage instruction is blocked.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the cause register reads 0 and the fault-address register reads 0. With no live request, take and all four flush outputs are low.
- R2: The cause codes are 0 for interrupt, 1 for fetch page fault, 2 for undefined instruction, 3 for overflow and 4 for data page fault. The code of a taken event appears on `cause` on the cycle after `take`.
- R3: When several requests are live together, the one from the deepest stage wins. The order is memory, then execute, then decode, then fetch.
- R4: On a take, `epc` shows the instruction address of the winning stage on the following cycle.
- R5: `take`, `cause_we` and `epc_we` rise together in the cycle of the decision, with no register in between. `handler_pc` carries the handler address, which defaults to 0x8000_0180.
- R6: The flush vector {flush_mem, flush_ex, flush_id, flush_if} covers the winning stage and all shallower stages, and no deeper stage. It is asserted only in the cycle of the take.
- R7: An interrupt is taken only when decode holds a valid instruction, with the decode address as `epc`. It loses to overflow and data page faults. It wins over an undefined-instruction fault on the same decode instruction, and over a fetch fault.
- R8: A fault flag raised while its stage's valid bit is low is ignored.
- R9: `mem_wr_en` follows `mem_wr_req`, except that it is forced low while the memory stage holds a valid instruction with a data page fault.
- R10: `cause` and `epc` keep their values in every cycle without a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_pc | input | 32 | Fetch instruction address |
| if_pgflt | input | 1 | Fetch page fault |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_pc | input | 32 | Decode instruction address |
| id_undef | input | 1 | Undefined opcode in decode |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_pc | input | 32 | Execute instruction address |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_pc | input | 32 | Memory instruction address |
| mem_pgflt | input | 1 | Data page fault in memory stage |
| irq | input | 1 | External interrupt request (level) |
| mem_wr_req | input | 1 | Store request from memory stage |
| mem_wr_en | output | 1 | Store enable after fault gating |
| take | output | 1 | Exception taken this cycle; selects the handler path of the PC mux |
| handler_pc | output | 32 | Handler address for the PC mux |
| cause_we | output | 1 | Cause register write enable |
| epc_we | output | 1 | Fault-address register write enable |
| flush_if | output | 1 | Clear the fetch stage's pipeline register |
| flush_id | output | 1 | Clear the decode stage's pipeline register |
| flush_ex | output | 1 | Clear the execute stage's pipeline register |
| flush_mem | output | 1 | Clear the memory stage's pipeline register |
| cause | output | 3 | Cause register |
| epc | output | 32 | Fault-address register |

## Verification
Some properties are checked by assertions on every cycle:
- A data page fault always produces cause 4 and the memory address on the next cycle.
- Every take flushes fetch.
- A lone interrupt with decode empty never causes a take.
- The cause and address registers stay stable whenever no write is enabled.

Only the bench scenarios can show the rest:
- The full ordering when several stages fault in the same cycle.
- The interrupt's standing against each fault type.
- The exact flush depth for each winning stage.
- The suppression of faults in empty stages.
- Store gating with and without a fault.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG   = 4;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CC_IRQ    = 3'd0,
    CC_IFETCH = 3'd1,
    CC_UNDEF  = 3'd2,
    CC_OVF    = 3'd3,
    CC_DMEM   = 3'd4
  } cause_e;

  // stage index grows with pipeline depth, i.e. with instruction age
  localparam int S_IF  = 0;
  localparam int S_ID  = 1;
  localparam int S_EX  = 2;
  localparam int S_MEM = 3;
endpackage

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int N  = NSTG,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][CODE_W-1:0] code,
  input  logic [N-1:0][AW-1:0]     pc,
  output logic                     hit,
  output logic [IW-1:0]            idx,
  output logic [CODE_W-1:0]        code_o,
  output logic [AW-1:0]            pc_o
);
  // ascending scan: the deepest (oldest) live request is assigned last and wins
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    code_o = '0;
    pc_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        hit    = 1'b1;
        idx    = IW'(k);
        code_o = code[k];
        pc_o   = pc[k];
      end
    end
  end
endmodule

// File: rtl/exc_csr.sv
module exc_csr
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cause_we,
  input  logic              epc_we,
  input  logic [CODE_W-1:0] cause_d,
  input  logic [AW-1:0]     epc_d,
  output logic [CODE_W-1:0] cause_q,
  output logic [AW-1:0]     epc_q
);
  logic [CODE_W-1:0] cause_n;
  logic [AW-1:0]     epc_n;

  always_comb begin
    cause_n = cause_q;
    epc_n   = epc_q;
    if (cause_we) cause_n = cause_d;
    if (epc_we)   epc_n   = epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_n;
      epc_q   <= epc_n;
    end
  end

  // R10: registers hold without a write enable
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause_we && !epc_we) |=> ($stable(cause_q) && $stable(epc_q)));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int           AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_valid,
  input  logic [AW-1:0]     if_pc,
  input  logic              if_pgflt,
  input  logic              id_valid,
  input  logic [AW-1:0]     id_pc,
  input  logic              id_undef,
  input  logic              ex_valid,
  input  logic [AW-1:0]     ex_pc,
  input  logic              ex_ovf,
  input  logic              mem_valid,
  input  logic [AW-1:0]     mem_pc,
  input  logic              mem_pgflt,
  input  logic              irq,
  input  logic              mem_wr_req,
  output logic              mem_wr_en,
  output logic              take,
  output logic [AW-1:0]     handler_pc,
  output logic              cause_we,
  output logic              epc_we,
  output logic              flush_if,
  output logic              flush_id,
  output logic              flush_ex,
  output logic              flush_mem,
  output logic [CODE_W-1:0] cause,
  output logic [AW-1:0]     epc
);
  localparam int IW = $clog2(NSTG);

  logic [NSTG-1:0]             req;
  logic [NSTG-1:0][CODE_W-1:0] code;
  logic [NSTG-1:0][AW-1:0]     spc;
  logic [NSTG-1:0]             flush_v;
  logic [IW-1:0]               sel_idx;
  logic [CODE_W-1:0]           sel_code;
  logic [AW-1:0]               sel_pc;

  // per-stage requests; the interrupt rides on the decode instruction
  always_comb begin
    req[S_IF]   = if_valid & if_pgflt;
    req[S_ID]   = id_valid & (id_undef | irq);
    req[S_EX]   = ex_valid & ex_ovf;
    req[S_MEM]  = mem_valid & mem_pgflt;
    code[S_IF]  = CC_IFETCH;
    code[S_ID]  = irq ? CC_IRQ : CC_UNDEF;
    code[S_EX]  = CC_OVF;
    code[S_MEM] = CC_DMEM;
    spc[S_IF]   = if_pc;
    spc[S_ID]   = id_pc;
    spc[S_EX]   = ex_pc;
    spc[S_MEM]  = mem_pc;
  end

  exc_pick #(.N(NSTG), .AW(AW)) u_pick (
    .req    (req),
    .code   (code),
    .pc     (spc),
    .hit    (take),
    .idx    (sel_idx),
    .code_o (sel_code),
    .pc_o   (sel_pc)
  );

  // flush the winning stage and every shallower (younger) stage
  for (genvar g = 0; g < NSTG; g++) begin : g_flush
    assign flush_v[g] = take && (sel_idx >= IW'(g));
  end

  assign flush_if   = flush_v[S_IF];
  assign flush_id   = flush_v[S_ID];
  assign flush_ex   = flush_v[S_EX];
  assign flush_mem  = flush_v[S_MEM];
  assign cause_we   = take;
  assign epc_we     = take;
  assign handler_pc = HANDLER_PC;
  assign mem_wr_en  = mem_wr_req & ~(mem_valid & mem_pgflt);

  exc_csr #(.AW(AW)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause_we (cause_we),
    .epc_we   (epc_we),
    .cause_d  (sel_code),
    .epc_d    (sel_pc),
    .cause_q  (cause),
    .epc_q    (epc)
  );

  // R3: a data page fault is always the oldest event and wins
  a_r3_dmem_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_pgflt) |=> (cause == CC_DMEM));
  // R4: the recorded address is the memory-stage address in that case
  a_r4_dmem_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_pgflt) |=> (epc == $past(mem_pc)));
  // R6: every take clears at least the fetch stage
  a_r6_flush_if: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> flush_if);
  // R7: an interrupt alone with decode empty is not taken
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !id_valid && !(if_valid && if_pgflt) && !(ex_valid && ex_ovf)
     && !(mem_valid && mem_pgflt)) |-> !take);
  // R9: no store leaves a faulting memory-stage instruction
  a_r9_no_fault_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_pgflt) |-> !mem_wr_en);
endmodule

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_valid, if_pgflt, id_valid, id_undef, ex_valid, ex_ovf;
  logic        mem_valid, mem_pgflt, irq, mem_wr_req;
  logic [31:0] if_pc, id_pc, ex_pc, mem_pc;
  logic        mem_wr_en, take, cause_we, epc_we;
  logic        flush_if, flush_id, flush_ex, flush_mem;
  logic [31:0] handler_pc, epc;
  logic [2:0]  cause;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { logic [2:0] c; logic [31:0] a; string tag; } item_t;
  item_t q[$];
  logic [2:0]  last_c = 3'd0;
  logic [31:0] last_a = 32'd0;

  always #2 clk = ~clk;

  exc_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, checks the same-cycle outputs,
  // and pushes the expected register contents for the monitor
  task automatic drive(
    input logic iv, input logic [31:0] ip, input logic ipf,
    input logic dv, input logic [31:0] dp, input logic dun,
    input logic ev, input logic [31:0] ep, input logic eov,
    input logic mv, input logic [31:0] mp, input logic mpf,
    input logic ir, input logic wr,
    input logic xt, input logic [2:0] xc, input logic [31:0] xa,
    input logic [3:0] xf, input logic xw, input string tag);
    @(negedge clk);
    if_valid = iv; if_pc = ip; if_pgflt = ipf;
    id_valid = dv; id_pc = dp; id_undef = dun;
    ex_valid = ev; ex_pc = ep; ex_ovf = eov;
    mem_valid = mv; mem_pc = mp; mem_pgflt = mpf;
    irq = ir; mem_wr_req = wr;
    #0.5;
    chk({tag, " take"}, 32'(take), 32'(xt));
    chk({tag, " we"}, 32'({cause_we, epc_we}), xt ? 32'd3 : 32'd0);
    chk({tag, " flush"}, 32'({flush_mem, flush_ex, flush_id, flush_if}), 32'(xf));
    chk({tag, " wr"}, 32'(mem_wr_en), 32'(xw));
    if (xt) begin
      chk({tag, " R5 handler"}, handler_pc, 32'h8000_0180);
      q.push_back('{c: xc, a: xa, tag: tag});
    end else begin
      q.push_back('{c: last_c, a: last_a, tag: {tag, " R10 hold"}});
    end
  endtask

  // monitor: one item per cycle, compared just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #0.5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " cause"}, 32'(cause), 32'(it.c));
        chk({it.tag, " epc"}, epc, it.a);
        last_c = it.c;
        last_a = it.a;
      end
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {if_valid, if_pgflt, id_valid, id_undef, ex_valid, ex_ovf} = '0;
    {mem_valid, mem_pgflt, irq, mem_wr_req} = '0;
    {if_pc, id_pc, ex_pc, mem_pc} = '0;
    #9;
    chk("R1 reset cause", 32'(cause), 32'd0);
    chk("R1 reset epc", epc, 32'd0);
    chk("R1 reset take", 32'(take), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    //    IF                  ID                  EX                  MEM                irq wr  take code addr      flush   wr
    drive(1,32'h100,0, 1,32'h0FC,0, 1,32'h0F8,0, 1,32'h0F4,0, 0,0, 0,3'd0,32'h0,   4'b0000,0, "R1 idle");
    drive(1,32'h100,1, 1,32'h0FC,0, 1,32'h0F8,0, 1,32'h0F4,0, 0,0, 1,3'd1,32'h100, 4'b0001,0, "R2 fetch fault");
    drive(1,32'h204,0, 1,32'h200,1, 1,32'h1FC,0, 1,32'h1F8,0, 0,0, 1,3'd2,32'h200, 4'b0011,0, "R2 undef");
    drive(1,32'h308,0, 1,32'h304,0, 1,32'h300,1, 1,32'h2FC,0, 0,0, 1,3'd3,32'h300, 4'b0111,0, "R2 overflow");
    drive(1,32'h40C,0, 1,32'h408,0, 1,32'h404,0, 1,32'h400,1, 0,1, 1,3'd4,32'h400, 4'b1111,0, "R9 R2 dmem fault");
    drive(1,32'h50C,1, 1,32'h508,1, 1,32'h504,1, 1,32'h500,1, 0,0, 1,3'd4,32'h500, 4'b1111,0, "R3 all four");
    drive(1,32'h60C,1, 1,32'h608,1, 1,32'h604,1, 1,32'h600,0, 0,0, 1,3'd3,32'h604, 4'b0111,0, "R3 R4 if+id+ex");
    drive(1,32'h70C,1, 1,32'h708,1, 0,32'h704,0, 0,32'h700,0, 0,0, 1,3'd2,32'h708, 4'b0011,0, "R3 if+id");
    drive(1,32'h80C,0, 1,32'h808,0, 1,32'h804,1, 0,32'h800,0, 1,0, 1,3'd3,32'h804, 4'b0111,0, "R7 irq loses to ovf");
    drive(1,32'h90C,0, 1,32'h908,0, 0,32'h904,0, 1,32'h900,1, 1,0, 1,3'd4,32'h900, 4'b1111,0, "R7 irq loses to dmem");
    drive(1,32'hA0C,0, 1,32'hA08,0, 1,32'hA04,0, 1,32'hA00,0, 1,0, 1,3'd0,32'hA08, 4'b0011,0, "R7 irq alone");
    drive(1,32'hB0C,0, 1,32'hB08,1, 0,32'hB04,0, 0,32'hB00,0, 1,0, 1,3'd0,32'hB08, 4'b0011,0, "R7 irq beats undef");
    drive(1,32'hC0C,1, 1,32'hC08,0, 0,32'hC04,0, 0,32'hC00,0, 1,0, 1,3'd0,32'hC08, 4'b0011,0, "R7 irq beats fetch");
    drive(0,32'hD0C,0, 0,32'hD08,0, 0,32'hD04,0, 0,32'hD00,0, 1,0, 0,3'd0,32'h0,   4'b0000,0, "R7 irq no decode");
    drive(0,32'hE0C,1, 0,32'hE08,1, 0,32'hE04,1, 0,32'hE00,1, 0,1, 0,3'd0,32'h0,   4'b0000,1, "R8 invalid faults");
    drive(1,32'hF0C,0, 1,32'hF08,0, 1,32'hF04,0, 1,32'hF00,0, 0,1, 0,3'd0,32'h0,   4'b0000,1, "R9 store passes");
    drive(0,32'h0,0,   0,32'h0,0,   1,32'h1234,1, 0,32'h0,0,  0,0, 1,3'd3,32'h1234,4'b0111,0, "R6 ex only");
    drive(0,32'h0,0,   0,32'h0,0,   0,32'h0,0,   0,32'h0,0,   0,0, 0,3'd0,32'h0,   4'b0000,0, "R6 R10 quiet");

    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule